// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the read-address, write-address and element/frame count sequence for a single DMA channel. A transfer is made of frames, and each frame is made of elements. The source side and the destination side each have their own 2-bit direction mode. In indexed mode, the step after every element uses a signed element stride, except after the final element of a frame, which uses a separate signed frame stride. The channel asks for reads with `rd_req` and counts a read whenever `rd_grant` arrives while that request is high. It asks for writes with `wr_req` and counts a write whenever `wr_done` arrives while that request is high. A write is never offered before the matching read has completed.

The configuration ports act as the channel's settings and also as its reload values. A `start` pulse while the channel is idle latches them and begins a block. With frame synchronization on, each frame waits for a sync event. The latched event is consumed when the first read of that frame is taken. With autoinitialization on, the channel reloads the configuration ports at the end of every block and runs again without software action. An emulation halt freezes the channel only when the pause bit is set.

Top module: `dma_addr_seq`

## Requirements
- R1: Direction code 00 keeps a side's address fixed, 01 adds ESIZE bytes after each element, and 10 subtracts ESIZE bytes after each element. The source side and the destination side are set independently, and all address arithmetic wraps modulo 2^AW.
- R2: With direction code 11, the address after an element that is not the last of its frame moves by the sign-extended element index. After the last element of a frame it moves by the sign-extended frame index.
- R3: Each side's element counter restarts at the configured element count at every frame boundary, so a multiframe block runs to the end without intervention. `frame_done` is high for exactly the one cycle after the edge that accepts the last write of each frame.
- R4: With frame sync on, the first read of each frame is requested only after a sync event has been latched, and one event releases the whole frame. The latch clears when that first read is accepted. An event that arrives during a frame, or in the same cycle as that first read, stays pending for the next frame.
- R5: `wr_req` is high only while the number of accepted reads is greater than the number of accepted writes. `rd_grant` and `wr_done` have no effect while their request is low.
- R6: `block_done` is high for exactly the one cycle after the edge that accepts the last write of the last frame. Without autoinitialization, `busy` is low in that same cycle, and neither request is raised while `busy` is low.
- R7: With `cfg_autoinit` high at a block end, the channel reloads its addresses and counts from the configuration ports, keeps `busy` high and begins the next block.
- R8: While `emu_halt` is high and the latched pause bit is 1, both requests are low and both addresses hold. With the pause bit 0, `emu_halt` has no effect.
- R9: A `start` with an element count or frame count of zero raises `block_done` in the next cycle. It makes no request, leaves `busy` low and leaves both addresses unchanged.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, both requests and both flags are low and both addresses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block from the configuration ports (idle only) |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_elem_cnt | input | CW | Elements per frame |
| cfg_frame_cnt | input | FW | Frames per block |
| cfg_src_dir | input | 2 | Source direction: 00 fixed, 01 up, 10 down, 11 indexed |
| cfg_dst_dir | input | 2 | Destination direction, same coding |
| cfg_elem_idx | input | IW | Signed stride inside a frame |
| cfg_frame_idx | input | IW | Signed stride after the last element of a frame |
| cfg_fsync_en | input | 1 | Frames wait for a sync event |
| cfg_emu_pause | input | 1 | Emulation halt pauses the channel |
| cfg_autoinit | input | 1 | Reload and restart at block end |
| sync_evt | input | 1 | Frame sync event |
| rd_grant | input | 1 | Read accepted at `rd_addr` |
| wr_done | input | 1 | Write completed at `wr_addr` |
| emu_halt | input | 1 | Emulation halt |
| rd_req | output | 1 | A read may be taken now |
| rd_addr | output | AW | Address of the next read |
| wr_req | output | 1 | A write may be completed now |
| wr_addr | output | AW | Address of the next write |
| busy | output | 1 | Block in progress |
| frame_done | output | 1 | One-cycle pulse after a frame's last write |
| block_done | output | 1 | One-cycle pulse after a block's last write |

## Verification
The assertions rely on the handshake inputs being sampled only together with their request. A grant or done that arrives while the request is low has no effect, so the stimulus may drive `rd_grant` and `wr_done` freely, whatever the request state. The address-hold properties also assume that the only things able to move an address are an accepted access, a start while idle, and a reload at block end. The bench therefore changes configuration ports only while the channel is idle, or at points where a reload is intended, and it holds `emu_halt` with the pause bit set long enough to watch both sides freeze.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      DIR_HOLD  = 2'b00,
      DIR_UP    = 2'b01,
      DIR_DOWN  = 2'b10,
      DIR_INDEX = 2'b11
   } dir_mode_e;

endpackage

// File: rtl/dma_seq_side.sv
module dma_seq_side
   import dma_seq_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 16,
   parameter int FW    = 16,
   parameter int IW    = 16,
   parameter int ESIZE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] cfg_addr,
   input  logic [CW-1:0] cfg_elems,
   input  logic [FW-1:0] cfg_frames,
   input  logic [1:0]    cfg_dir,
   input  logic [IW-1:0] cfg_eidx,
   input  logic [IW-1:0] cfg_fidx,
   input  logic          adv,
   output logic [AW-1:0] addr,
   output logic          at_first,
   output logic          at_last,
   output logic          last_frame,
   output logic          exhausted
);

   localparam logic [AW-1:0] SIZE_STEP = AW'(ESIZE);
   localparam logic [CW-1:0] ONE_ELEM  = CW'(1);
   localparam logic [FW-1:0] ONE_FRAME = FW'(1);

   logic [AW-1:0] addr_q;
   logic [CW-1:0] elem_left_q;
   logic [CW-1:0] elem_rld_q;
   logic [FW-1:0] frame_left_q;
   dir_mode_e     dir_q;
   logic [IW-1:0] eidx_q;
   logic [IW-1:0] fidx_q;
   logic [AW-1:0] eidx_x;
   logic [AW-1:0] fidx_x;
   logic [AW-1:0] step;

   generate
      if (IW == AW) begin : g_idx_same
         assign eidx_x = eidx_q;
         assign fidx_x = fidx_q;
      end else begin : g_idx_sext
         assign eidx_x = {{(AW-IW){eidx_q[IW-1]}}, eidx_q};
         assign fidx_x = {{(AW-IW){fidx_q[IW-1]}}, fidx_q};
      end
   endgenerate

   assign at_last    = (elem_left_q == ONE_ELEM);
   assign at_first   = (elem_left_q == elem_rld_q);
   assign last_frame = (frame_left_q == ONE_FRAME);
   assign exhausted  = (frame_left_q == '0);
   assign addr       = addr_q;

   always_comb begin
      unique case (dir_q)
         DIR_HOLD:  step = '0;
         DIR_UP:    step = SIZE_STEP;
         DIR_DOWN:  step = '0 - SIZE_STEP;
         default:   step = at_last ? fidx_x : eidx_x;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q       <= '0;
         elem_left_q  <= '0;
         elem_rld_q   <= '0;
         frame_left_q <= '0;
         dir_q        <= DIR_HOLD;
         eidx_q       <= '0;
         fidx_q       <= '0;
      end else if (load) begin
         addr_q       <= cfg_addr;
         elem_left_q  <= cfg_elems;
         elem_rld_q   <= cfg_elems;
         frame_left_q <= cfg_frames;
         dir_q        <= dir_mode_e'(cfg_dir);
         eidx_q       <= cfg_eidx;
         fidx_q       <= cfg_fidx;
      end else if (adv) begin
         addr_q <= addr_q + step;
         if (at_last) begin
            elem_left_q  <= elem_rld_q;
            frame_left_q <= frame_left_q - ONE_FRAME;
         end else begin
            elem_left_q <= elem_left_q - ONE_ELEM;
         end
      end
   end

endmodule

// File: rtl/dma_seq_sync.sv
module dma_seq_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic evt,
   input  logic consume,
   output logic pend
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend <= 1'b0;
      else if (flush)   pend <= 1'b0;
      else if (evt)     pend <= 1'b1;
      else if (consume) pend <= 1'b0;
   end

endmodule

// File: rtl/dma_seq_balance.sv
module dma_seq_balance #(
   parameter int TW = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   input  logic dec,
   output logic ahead
);

   logic [TW-1:0] gap_q;

   assign ahead = (gap_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gap_q <= '0;
      else if (clear)  gap_q <= '0;
      else if (inc && !dec) gap_q <= gap_q + TW'(1);
      else if (dec && !inc) gap_q <= gap_q - TW'(1);
   end

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
   parameter int AW    = 32,
   parameter int CW    = 16,
   parameter int FW    = 16,
   parameter int IW    = 16,
   parameter int ESIZE = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] cfg_src_addr,
   input  logic [AW-1:0] cfg_dst_addr,
   input  logic [CW-1:0] cfg_elem_cnt,
   input  logic [FW-1:0] cfg_frame_cnt,
   input  logic [1:0]    cfg_src_dir,
   input  logic [1:0]    cfg_dst_dir,
   input  logic [IW-1:0] cfg_elem_idx,
   input  logic [IW-1:0] cfg_frame_idx,
   input  logic          cfg_fsync_en,
   input  logic          cfg_emu_pause,
   input  logic          cfg_autoinit,
   input  logic          sync_evt,
   input  logic          rd_grant,
   input  logic          wr_done,
   input  logic          emu_halt,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   output logic          wr_req,
   output logic [AW-1:0] wr_addr,
   output logic          busy,
   output logic          frame_done,
   output logic          block_done
);

   localparam int TW = CW + FW;

   generate
      if (IW > AW) begin : g_bad_idx
         $error("dma_addr_seq: IW must not exceed AW");
      end
      if (ESIZE < 1) begin : g_bad_size
         $error("dma_addr_seq: ESIZE must be at least 1");
      end
      if (CW < 1 || FW < 1) begin : g_bad_cnt
         $error("dma_addr_seq: count widths must be positive");
      end
   endgenerate

   logic busy_q, fsync_q, pause_q;
   logic fdone_q, bdone_q;
   logic zero_cfg, start_ok, load_new, reload, load_any;
   logic paused, rd_fire, wr_fire, blk_end;
   logic sync_pend, gap_nz;
   logic rd_first, rd_last, rd_lastfr, rd_exh;
   logic wr_first, wr_last, wr_lastfr, wr_exh;
   logic unused_side;

   assign zero_cfg = (cfg_elem_cnt == '0) || (cfg_frame_cnt == '0);
   assign start_ok = start && !busy_q;
   assign load_new = start_ok && !zero_cfg;
   assign paused   = emu_halt && pause_q;

   assign rd_req  = busy_q && !rd_exh && !paused &&
                    (!fsync_q || !rd_first || sync_pend);
   assign wr_req  = busy_q && gap_nz && !paused;
   assign rd_fire = rd_grant && rd_req;
   assign wr_fire = wr_done && wr_req;
   assign blk_end = wr_fire && wr_last && wr_lastfr;
   assign reload  = blk_end && cfg_autoinit && !zero_cfg;
   assign load_any = load_new || reload;

   assign unused_side = ^{rd_last, rd_lastfr, wr_first, wr_exh};

   dma_seq_side #(.AW(AW), .CW(CW), .FW(FW), .IW(IW), .ESIZE(ESIZE)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_any),
      .cfg_addr   (cfg_src_addr),
      .cfg_elems  (cfg_elem_cnt),
      .cfg_frames (cfg_frame_cnt),
      .cfg_dir    (cfg_src_dir),
      .cfg_eidx   (cfg_elem_idx),
      .cfg_fidx   (cfg_frame_idx),
      .adv        (rd_fire),
      .addr       (rd_addr),
      .at_first   (rd_first),
      .at_last    (rd_last),
      .last_frame (rd_lastfr),
      .exhausted  (rd_exh)
   );

   dma_seq_side #(.AW(AW), .CW(CW), .FW(FW), .IW(IW), .ESIZE(ESIZE)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_any),
      .cfg_addr   (cfg_dst_addr),
      .cfg_elems  (cfg_elem_cnt),
      .cfg_frames (cfg_frame_cnt),
      .cfg_dir    (cfg_dst_dir),
      .cfg_eidx   (cfg_elem_idx),
      .cfg_fidx   (cfg_frame_idx),
      .adv        (wr_fire),
      .addr       (wr_addr),
      .at_first   (wr_first),
      .at_last    (wr_last),
      .last_frame (wr_lastfr),
      .exhausted  (wr_exh)
   );

   dma_seq_sync u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (load_new),
      .evt     (sync_evt),
      .consume (rd_fire && rd_first),
      .pend    (sync_pend)
   );

   dma_seq_balance #(.TW(TW)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load_any),
      .inc   (rd_fire),
      .dec   (wr_fire),
      .ahead (gap_nz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         fsync_q <= 1'b0;
         pause_q <= 1'b0;
         fdone_q <= 1'b0;
         bdone_q <= 1'b0;
      end else begin
         fdone_q <= wr_fire && wr_last;
         bdone_q <= blk_end || (start_ok && zero_cfg);
         if (load_any) begin
            fsync_q <= cfg_fsync_en;
            pause_q <= cfg_emu_pause;
         end
         if (load_new)     busy_q <= 1'b1;
         else if (blk_end) busy_q <= reload;
      end
   end

   assign busy       = busy_q;
   assign frame_done = fdone_q;
   assign block_done = bdone_q;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          rd_req,
   input logic          wr_req,
   input logic          rd_grant,
   input logic          wr_done,
   input logic [AW-1:0] rd_addr,
   input logic [AW-1:0] wr_addr,
   input logic          emu_halt,
   input logic          pause_q,
   input logic          cfg_autoinit,
   input logic          block_done
);

   logic [63:0] rd_total, wr_total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_total <= '0;
         wr_total <= '0;
      end else begin
         if (rd_grant && rd_req) rd_total <= rd_total + 64'd1;
         if (wr_done && wr_req)  wr_total <= wr_total + 64'd1;
      end
   end

   // R6: an idle channel raises no request
   p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req && !wr_req));

   // R6: without autoinit, a block end leaves the channel idle
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (block_done && !$past(cfg_autoinit)) |-> !busy);

   // R9: idle without start keeps both addresses
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(rd_addr) && $stable(wr_addr)));

   // R5: writes never outnumber reads
   p_wr_behind_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_total <= rd_total);

   // R5: a write is offered only with a read outstanding
   p_wr_backed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (rd_total > wr_total));

   // R8: paused halt freezes both addresses
   p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && emu_halt && pause_q) |=> ($stable(rd_addr) && $stable(wr_addr)));

endmodule

bind dma_addr_seq dma_seq_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .rd_req       (rd_req),
   .wr_req       (wr_req),
   .rd_grant     (rd_grant),
   .wr_done      (wr_done),
   .rd_addr      (rd_addr),
   .wr_addr      (wr_addr),
   .emu_halt     (emu_halt),
   .pause_q      (pause_q),
   .cfg_autoinit (cfg_autoinit),
   .block_done   (block_done)
);

// File: tb/dma_addr_seq_bench.sv
module dma_addr_seq_bench;

   localparam int AW = 32;
   localparam int CW = 16;
   localparam int FW = 16;
   localparam int IW = 16;
   localparam int MAXN = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          start = 0, sync_evt = 0, rd_grant = 0, wr_done = 0, emu_halt = 0;
   logic [AW-1:0] cfg_src_addr = 0, cfg_dst_addr = 0;
   logic [CW-1:0] cfg_elem_cnt = 0;
   logic [FW-1:0] cfg_frame_cnt = 0;
   logic [1:0]    cfg_src_dir = 0, cfg_dst_dir = 0;
   logic [IW-1:0] cfg_elem_idx = 0, cfg_frame_idx = 0;
   logic          cfg_fsync_en = 0, cfg_emu_pause = 0, cfg_autoinit = 0;
   logic          rd_req, wr_req, busy, frame_done, block_done;
   logic [AW-1:0] rd_addr, wr_addr;

   dma_addr_seq #(.AW(AW), .CW(CW), .FW(FW), .IW(IW), .ESIZE(4)) u_dma_addr_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
      .cfg_elem_cnt(cfg_elem_cnt), .cfg_frame_cnt(cfg_frame_cnt),
      .cfg_src_dir(cfg_src_dir), .cfg_dst_dir(cfg_dst_dir),
      .cfg_elem_idx(cfg_elem_idx), .cfg_frame_idx(cfg_frame_idx),
      .cfg_fsync_en(cfg_fsync_en), .cfg_emu_pause(cfg_emu_pause),
      .cfg_autoinit(cfg_autoinit), .sync_evt(sync_evt), .rd_grant(rd_grant),
      .wr_done(wr_done), .emu_halt(emu_halt), .rd_req(rd_req), .rd_addr(rd_addr),
      .wr_req(wr_req), .wr_addr(wr_addr), .busy(busy),
      .frame_done(frame_done), .block_done(block_done)
   );

   int checks = 0, failures = 0, cyc = 0;
   string tag = "R11";
   int rd_pct = 0, wr_pct = 0;
   int bd_seen = 0, fd_seen = 0, rd_seen = 0;

   // reference model state
   bit m_busy, m_pend, m_fs, m_pause, m_fd, m_bd;
   int m_E, m_F, m_N, m_ri, m_wi;
   logic [AW-1:0] m_rd, m_wr;
   logic [AW-1:0] sarr [0:MAXN];
   logic [AW-1:0] darr [0:MAXN];
   bit rf, wf, clr, ldn;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] stride(input logic [1:0] dir, input bit last);
      logic [AW-1:0] e, f;
      e = {{(AW-IW){cfg_elem_idx[IW-1]}}, cfg_elem_idx};
      f = {{(AW-IW){cfg_frame_idx[IW-1]}}, cfg_frame_idx};
      case (dir)
         2'b00:   return '0;
         2'b01:   return 32'd4;
         2'b10:   return 32'hFFFF_FFFC;
         default: return last ? f : e;
      endcase
   endfunction

   task automatic model_load();
      logic [AW-1:0] a, b;
      m_E = int'(cfg_elem_cnt);
      m_F = int'(cfg_frame_cnt);
      m_N = m_E * m_F;
      a = cfg_src_addr;
      b = cfg_dst_addr;
      for (int k = 0; k <= m_N && k <= MAXN; k++) begin
         sarr[k] = a;
         darr[k] = b;
         a = a + stride(cfg_src_dir, (k % m_E) == m_E - 1);
         b = b + stride(cfg_dst_dir, (k % m_E) == m_E - 1);
      end
      m_ri = 0; m_wi = 0;
      m_rd = sarr[0]; m_wr = darr[0];
      m_fs = cfg_fsync_en; m_pause = cfg_emu_pause;
      m_busy = 1;
   endtask

   function automatic bit e_rdreq();
      return m_busy && m_ri < m_N && !(emu_halt && m_pause) &&
             (!m_fs || (m_ri % m_E) != 0 || m_pend);
   endfunction

   function automatic bit e_wrreq();
      return m_busy && m_wi < m_ri && !(emu_halt && m_pause);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_pend = 0; m_fs = 0; m_pause = 0; m_fd = 0; m_bd = 0;
         m_rd = 0; m_wr = 0; m_N = 0; m_E = 1; m_ri = 0; m_wi = 0;
      end else begin
         rf = rd_grant && e_rdreq();
         wf = wr_done && e_wrreq();
         clr = 0; ldn = 0; m_fd = 0; m_bd = 0;
         if (!m_busy) begin
            if (start) begin
               if (cfg_elem_cnt == 0 || cfg_frame_cnt == 0) m_bd = 1;
               else begin model_load(); ldn = 1; end
            end
         end else begin
            if (rf) begin
               if (m_fs && (m_ri % m_E) == 0) clr = 1;
               m_ri++;
               m_rd = sarr[m_ri];
            end
            if (wf) begin
               m_wi++;
               m_wr = darr[m_wi];
               if ((m_wi % m_E) == 0) m_fd = 1;
               if (m_wi == m_N) begin
                  m_bd = 1;
                  if (cfg_autoinit && cfg_elem_cnt != 0 && cfg_frame_cnt != 0) model_load();
                  else m_busy = 0;
               end
            end
         end
         if (ldn) m_pend = 0;
         else if (sync_evt) m_pend = 1;
         else if (clr) m_pend = 0;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy == m_busy, tag, "busy", busy, m_busy);
         chk(rd_req == e_rdreq(), tag, "rd_req", rd_req, e_rdreq());
         chk(wr_req == e_wrreq(), tag, "wr_req", wr_req, e_wrreq());
         chk(rd_addr == m_rd, tag, "rd_addr", rd_addr, m_rd);
         chk(wr_addr == m_wr, tag, "wr_addr", wr_addr, m_wr);
         chk(frame_done == m_fd, tag, "frame_done", frame_done, m_fd);
         chk(block_done == m_bd, tag, "block_done", block_done, m_bd);
         if (block_done) bd_seen++;
         if (frame_done) fd_seen++;
         if (rd_req && rd_grant) rd_seen++;
      end
   end

   // handshake driver
   always @(posedge clk) begin
      #3;
      rd_grant <= ($urandom % 100) < rd_pct;
      wr_done  <= ($urandom % 100) < wr_pct;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog %s expired", tag);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #3; end
   endtask

   task automatic pulse_start();
      tick(1); start = 1; tick(1); start = 0;
   endtask

   task automatic pulse_sync();
      tick(1); sync_evt = 1; tick(1); sync_evt = 0;
   endtask

   task automatic wait_block(input int maxc);
      int b0 = bd_seen;
      int n = 0;
      while (bd_seen == b0 && n < maxc) begin @(negedge clk); #1; n++; end
      chk(bd_seen != b0, tag, "block_done reached", bd_seen, b0 + 1);
   endtask

   task automatic setup(input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input int e, input int f, input logic [1:0] sd, input logic [1:0] dd);
      tick(1);
      cfg_src_addr = s; cfg_dst_addr = d;
      cfg_elem_cnt = CW'(e); cfg_frame_cnt = FW'(f);
      cfg_src_dir = sd; cfg_dst_dir = dd;
   endtask

   initial begin
      int f0, r0;
      logic [AW-1:0] keep_r, keep_w;
      tick(3);
      rst_n = 1;
      @(negedge clk); #1;
      tag = "R11";
      chk(busy == 0 && rd_req == 0 && wr_req == 0, "R11", "idle after reset", busy, 0);
      chk(rd_addr == 0 && wr_addr == 0, "R11", "addresses after reset", rd_addr, 0);

      // R1: up / down, then fixed / up
      tag = "R1"; rd_pct = 100; wr_pct = 100;
      setup(32'h1000, 32'h2000, 3, 2, 2'b01, 2'b10);
      pulse_start(); wait_block(200);
      chk(rd_addr == 32'h1018, "R1", "src after up", rd_addr, 32'h1018);
      chk(wr_addr == 32'h1FE8, "R1", "dst after down", wr_addr, 32'h1FE8);
      setup(32'h3000, 32'h4000, 2, 2, 2'b00, 2'b01);
      pulse_start(); wait_block(200);
      chk(rd_addr == 32'h3000, "R1", "src fixed", rd_addr, 32'h3000);
      chk(wr_addr == 32'h4010, "R1", "dst up", wr_addr, 32'h4010);

      // R2: indexed with element and frame strides
      tag = "R2"; rd_pct = 60; wr_pct = 60;
      setup(32'h0100, 32'h0800, 4, 3, 2'b11, 2'b11);
      cfg_elem_idx = 16'd8; cfg_frame_idx = 16'hFFEC;
      pulse_start(); wait_block(2000);
      chk(rd_addr == 32'h010C, "R2", "src indexed end", rd_addr, 32'h010C);
      chk(wr_addr == 32'h080C, "R2", "dst indexed end", wr_addr, 32'h080C);

      // R3: frame boundaries
      tag = "R3"; rd_pct = 70; wr_pct = 70;
      setup(32'h0, 32'h100, 5, 3, 2'b01, 2'b01);
      f0 = fd_seen;
      pulse_start(); wait_block(2000);
      chk(fd_seen - f0 == 3, "R3", "frame_done pulses", fd_seen - f0, 3);

      // R4: frame sync
      tag = "R4"; rd_pct = 100; wr_pct = 100;
      setup(32'h200, 32'h300, 3, 3, 2'b01, 2'b01);
      cfg_fsync_en = 1;
      pulse_start(); tick(8);
      @(negedge clk); #1;
      chk(rd_req == 0 && busy == 1, "R4", "waits for sync", rd_req, 0);
      r0 = rd_seen;
      pulse_sync(); tick(10);
      @(negedge clk); #1;
      chk(rd_seen - r0 == 3, "R4", "one frame per event", rd_seen - r0, 3);
      chk(rd_req == 0, "R4", "next frame waits", rd_req, 0);
      pulse_sync(); pulse_sync();
      wait_block(200);
      chk(rd_addr == 32'h224, "R4", "all frames read", rd_addr, 32'h224);
      cfg_fsync_en = 0;

      // R5: writes trail reads
      tag = "R5"; rd_pct = 100; wr_pct = 0;
      setup(32'h400, 32'h500, 4, 2, 2'b01, 2'b01);
      pulse_start(); tick(1); rd_pct = 0; wr_pct = 100; tick(8);
      @(negedge clk); #1;
      chk(wr_req == 0 && busy == 1, "R5", "no write past reads", wr_req, 0);
      rd_pct = 100; wait_block(200);

      // R8: pause on halt, then halt without pause
      tag = "R8"; rd_pct = 100; wr_pct = 100;
      setup(32'h600, 32'h700, 4, 2, 2'b01, 2'b01);
      cfg_emu_pause = 1;
      tick(1); start = 1; emu_halt = 1; tick(1); start = 0; tick(6);
      @(negedge clk); #1;
      chk(rd_req == 0 && wr_req == 0, "R8", "requests frozen", rd_req, 0);
      chk(rd_addr == 32'h600 && busy == 1, "R8", "address held", rd_addr, 32'h600);
      tick(1); emu_halt = 0; wait_block(200);
      cfg_emu_pause = 0;
      pulse_start(); tick(1); emu_halt = 1; wait_block(200);
      chk(rd_addr == 32'h620, "R8", "halt ignored when pause off", rd_addr, 32'h620);
      tick(1); emu_halt = 0;

      // R7: autoinit reload, then stop
      tag = "R7";
      setup(32'h800, 32'h900, 2, 2, 2'b01, 2'b10);
      cfg_autoinit = 1;
      pulse_start(); wait_block(200);
      chk(busy == 1, "R7", "busy after first block", busy, 1);
      wait_block(200);
      chk(busy == 1, "R7", "busy after second block", busy, 1);
      tick(1); cfg_autoinit = 0;
      wait_block(200);
      chk(busy == 0, "R6", "idle after final block", busy, 0);

      // R9: zero counts
      tag = "R9";
      keep_r = rd_addr; keep_w = wr_addr;
      setup(32'hA000, 32'hB000, 0, 3, 2'b01, 2'b01);
      pulse_start();
      @(negedge clk); #1;
      chk(block_done == 1 && busy == 0, "R9", "zero elements done", block_done, 1);
      chk(rd_addr == keep_r && wr_addr == keep_w, "R9", "addresses kept", rd_addr, keep_r);
      setup(32'hA000, 32'hB000, 2, 0, 2'b01, 2'b01);
      pulse_start();
      @(negedge clk); #1;
      chk(block_done == 1 && rd_req == 0, "R9", "zero frames done", block_done, 1);

      // R10: start ignored while busy
      tag = "R10"; rd_pct = 50; wr_pct = 50;
      setup(32'h5000, 32'h6000, 3, 2, 2'b01, 2'b01);
      pulse_start(); tick(2);
      cfg_src_addr = 32'h9000; cfg_elem_cnt = 16'd1;
      start = 1; tick(1); start = 0;
      cfg_src_addr = 32'h5000; cfg_elem_cnt = 16'd3;
      wait_block(2000);
      chk(rd_addr == 32'h5018, "R10", "first block kept", rd_addr, 32'h5018);

      tick(4);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule